// File: doc/BRIEF.md
# Sixteen-Bit Register-Pair Adder with Flag Merge

This combinational unit sits in the datapath of an 8-bit processor. It serves the wide-add instruction class, where a register pair, the stack pointer or an index register is added into a 16-bit destination. It takes two 16-bit operands and the current flag byte. It returns the truncated 16-bit sum and a new flag byte. Only carry, half-carry, subtract and the two spare bits are rebuilt. Sign, zero and parity/overflow come through untouched.

The same adder also handles the wide increment and decrement of a register pair. Both wrap modulo 65536 and hand the incoming flag byte back unmodified. An operation code selects the mode. Register storage, decode and memory access live elsewhere.

The flag byte layout is C=bit0, N=bit1, P/V=bit2, spare bit3, H=bit4, spare bit5, Z=bit6, S=bit7.

Top module: `wadd_unit`

## Requirements
- R1: With `op_sel` equal to 2'b00 or 2'b11 (add), `sum_out` equals the low 16 bits of `opnd_a + opnd_b`.
- R2: In add mode, `flags_out[0]` (carry) is 1 exactly when the unsigned 17-bit sum `opnd_a + opnd_b` is at least 65536.
- R3: In add mode, `flags_out[7]` (sign), `flags_out[6]` (zero) and `flags_out[2]` (parity/overflow) equal the same bits of `flags_in`.
- R4: In add mode, `flags_out[4]` (half-carry) is 1 exactly when the low 12 bits of the two operands, added as unsigned numbers, reach 4096, which is a carry from bit 11 into bit 12.
- R5: In add mode, `flags_out[3]` equals bit 11 of the 16-bit sum and `flags_out[5]` equals bit 13 of the 16-bit sum.
- R6: In add mode, `flags_out[1]` (subtract) is 0 whatever `flags_in[1]` is.
- R7: With `op_sel` equal to 2'b01 (increment), `sum_out` is `(opnd_a + 1) mod 65536`, `opnd_b` has no effect, and `flags_out` equals `flags_in`.
- R8: With `op_sel` equal to 2'b10 (decrement), `sum_out` is `(opnd_a - 1) mod 65536`, `opnd_b` has no effect, and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Mode: 00/11 add, 01 increment, 10 decrement |
| opnd_a | input | 16 | Destination operand (first addend, or pair to step) |
| opnd_b | input | 16 | Source operand for add mode |
| flags_in | input | 8 | Current flag byte |
| sum_out | output | 16 | Result written back to the destination |
| flags_out | output | 8 | Updated flag byte |

## Verification
A carry out of bit 11 and a carry out of bit 15 can arise from the same addition. A second collision is the increment of 0xFFFF: it wraps the sum but must leave the carry flag alone. The bench provokes both with fixed vectors, namely 0xFFFF+1, 0x7FFF+0x8001 and an increment of 0xFFFF. It also provokes them with random operands whose low 12 bits are forced high. Each flag field is judged separately against an integer model, so a wrong carry cannot be hidden by a correct half-carry, and the reverse holds too.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

  typedef enum logic [1:0] {
    WOP_ADD     = 2'b00,
    WOP_INC     = 2'b01,
    WOP_DEC     = 2'b10,
    WOP_ADD_ALT = 2'b11
  } wop_e;

  localparam int FLAG_W   = 8;
  localparam int FB_C     = 0;
  localparam int FB_N     = 1;
  localparam int FB_PV    = 2;
  localparam int FB_X3    = 3;
  localparam int FB_H     = 4;
  localparam int FB_X5    = 5;
  localparam int FB_Z     = 6;
  localparam int FB_S     = 7;
  localparam int NIBBLE_W = 4;

  function automatic logic is_add_op(input wop_e op);
    return (op == WOP_ADD) || (op == WOP_ADD_ALT);
  endfunction

  // sum and carry-out of one 4-bit slice
  function automatic logic [NIBBLE_W:0] nib_add(input logic [NIBBLE_W-1:0] x,
                                                input logic [NIBBLE_W-1:0] y,
                                                input logic cin);
    return {1'b0, x} + {1'b0, y} + {{NIBBLE_W{1'b0}}, cin};
  endfunction

  // keep mask: bits that survive a wide add
  function automatic logic [FLAG_W-1:0] keep_mask();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[FB_S]  = 1'b1;
    m[FB_Z]  = 1'b1;
    m[FB_PV] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/wadd_arith.sv
module wadd_arith
  import wadd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  wop_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              carry_top,
  output logic              carry_hc,
  output logic              add_mode
);

  localparam int NIBS   = DATA_W / NIBBLE_W;
  localparam int HC_NIB = NIBS - 2;

  logic [DATA_W-1:0] b_eff;
  logic [NIBS:0]     chain;

  always_comb begin
    unique case (op)
      WOP_INC: b_eff = {{(DATA_W-1){1'b0}}, 1'b1};
      WOP_DEC: b_eff = {DATA_W{1'b1}};
      default: b_eff = b;
    endcase
  end

  assign chain[0] = 1'b0;

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    logic [NIBBLE_W:0] part;
    assign part = nib_add(a[k*NIBBLE_W +: NIBBLE_W],
                          b_eff[k*NIBBLE_W +: NIBBLE_W], chain[k]);
    assign res[k*NIBBLE_W +: NIBBLE_W] = part[NIBBLE_W-1:0];
    assign chain[k+1] = part[NIBBLE_W];
  end

  assign carry_top = chain[NIBS];
  assign carry_hc  = chain[HC_NIB+1];
  assign add_mode  = is_add_op(op);

endmodule

// File: rtl/wadd_flags.sv
module wadd_flags
  import wadd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              add_mode,
  input  logic              carry_top,
  input  logic              carry_hc,
  input  logic [DATA_W-1:0] res,
  input  logic [FLAG_W-1:0] f_in,
  output logic [FLAG_W-1:0] f_out
);

  localparam int HI_BASE = DATA_W - 8;

  logic [FLAG_W-1:0] rebuilt;

  always_comb begin
    rebuilt        = f_in & keep_mask();
    rebuilt[FB_C]  = carry_top;
    rebuilt[FB_N]  = 1'b0;
    rebuilt[FB_H]  = carry_hc;
    rebuilt[FB_X3] = res[HI_BASE + 3];
    rebuilt[FB_X5] = res[HI_BASE + 5];
    f_out          = add_mode ? rebuilt : f_in;
  end

endmodule

// File: rtl/wadd_unit.sv
module wadd_unit
  import wadd_pkg::*;
(
  input  logic [1:0]  op_sel,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [7:0]  flags_in,
  output logic [15:0] sum_out,
  output logic [7:0]  flags_out
);

  localparam int DATA_W = 16;

  wop_e op;
  logic evt_carry;
  logic evt_half;
  logic evt_add;

  assign op = wop_e'(op_sel);

  wadd_arith #(.DATA_W(DATA_W)) u_arith (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .res       (sum_out),
    .carry_top (evt_carry),
    .carry_hc  (evt_half),
    .add_mode  (evt_add)
  );

  wadd_flags #(.DATA_W(DATA_W)) u_flags (
    .add_mode  (evt_add),
    .carry_top (evt_carry),
    .carry_hc  (evt_half),
    .res       (sum_out),
    .f_in      (flags_in),
    .f_out     (flags_out)
  );

endmodule

// File: rtl/wadd_unit_chk.sv
module wadd_unit_chk (
  input logic [1:0]  op_sel,
  input logic [15:0] opnd_a,
  input logic [15:0] opnd_b,
  input logic [7:0]  flags_in,
  input logic [15:0] sum_out,
  input logic [7:0]  flags_out,
  input logic        evt_carry,
  input logic        evt_half
);

  logic        add_m;
  logic [31:0] wide;
  logic [31:0] low12;

  always_comb begin
    add_m = (op_sel == 2'b00) || (op_sel == 2'b11);
    wide  = {16'h0, opnd_a} + {16'h0, opnd_b};
    low12 = {20'h0, opnd_a[11:0]} + {20'h0, opnd_b[11:0]};
    if (add_m) begin
      AST_ADD_SUM: assert (sum_out == wide[15:0]);                                  // R1
      AST_ADD_CARRY: assert (flags_out[0] == (wide > 32'h0000_FFFF));               // R2
      AST_CARRY_EVT: assert (evt_carry == flags_out[0]);                            // R2
      AST_KEEP_SZP: assert (flags_out[7:6] == flags_in[7:6] && flags_out[2] == flags_in[2]); // R3
      AST_HALF_CARRY: assert (evt_half == (low12 > 32'd4095));                      // R4
      AST_SPARE_BITS: assert (flags_out[3] == sum_out[11] && flags_out[5] == sum_out[13]); // R5
      AST_SUB_CLEAR: assert (flags_out[1] == 1'b0);                                 // R6
    end
    if (op_sel == 2'b01) begin
      AST_INC_VALUE: assert (sum_out == opnd_a + 16'd1 && flags_out == flags_in);   // R7
    end
    if (op_sel == 2'b10) begin
      AST_DEC_VALUE: assert (sum_out == opnd_a - 16'd1 && flags_out == flags_in);   // R8
    end
  end

endmodule

bind wadd_unit wadd_unit_chk chk_i (
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .flags_in  (flags_in),
  .sum_out   (sum_out),
  .flags_out (flags_out),
  .evt_carry (evt_carry),
  .evt_half  (evt_half)
);

// File: tb/wadd_unit_tb.sv
module wadd_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic [7:0]  flags_in;
  logic [15:0] sum_out;
  logic [7:0]  flags_out;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wadd_unit dut_i (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .sum_out   (sum_out),
    .flags_out (flags_out)
  );

  typedef struct {
    int op;
    int a;
    int b;
    int f;
  } vec_t;

  vec_t q[$];

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (op=%0d a=%h b=%h f=%h)",
               req, act, exp, op_sel, opnd_a, opnd_b, flags_in);
    end
  endtask

  // reference model on integers, compared every cycle
  task automatic judge();
    int a, b, f, s, c, h, exp_sum;
    a = opnd_a; b = opnd_b; f = flags_in;
    if (op_sel == 2'b01 || op_sel == 2'b10) begin
      exp_sum = (op_sel == 2'b01) ? (a + 1) % 65536 : (a + 65535) % 65536;
      cmp(op_sel == 2'b01 ? "R7 step sum" : "R8 step sum", sum_out, exp_sum);
      cmp(op_sel == 2'b01 ? "R7 flags" : "R8 flags", flags_out, f);
    end else begin
      s = a + b;
      c = s / 65536;
      h = ((a % 4096) + (b % 4096)) / 4096;
      cmp("R1 sum", sum_out, s % 65536);
      cmp("R2 carry", flags_out & 1, c);
      cmp("R3 S/Z/PV", flags_out & 8'hC4, f & 8'hC4);
      cmp("R4 half", (flags_out / 16) & 1, h);
      cmp("R5 bit3", (flags_out / 8) & 1, ((s % 65536) / 2048) & 1);
      cmp("R5 bit5", (flags_out / 32) & 1, ((s % 65536) / 8192) & 1);
      cmp("R6 sub", (flags_out / 2) & 1, 0);
    end
  endtask

  function automatic vec_t mk(int op, int a, int b, int f);
    vec_t v;
    v.op = op; v.a = a; v.b = b; v.f = f;
    return v;
  endfunction

  initial begin
    op_sel = 2'b00; opnd_a = '0; opnd_b = '0; flags_in = '0;
    // reset-time idle pattern: all zero in, all zero out
    q.push_back(mk(0, 16'h0000, 16'h0000, 8'h00));
    // corner: carry out of bit 11 and bit 15 together (R2, R4)
    q.push_back(mk(0, 16'hFFFF, 16'h0001, 8'hFF));
    q.push_back(mk(0, 16'h0FFF, 16'h0001, 8'h00));
    q.push_back(mk(0, 16'h7FFF, 16'h8001, 8'h3B));
    q.push_back(mk(3, 16'h2800, 16'h0800, 8'hC6));
    // step wrap cases (R7, R8), opnd_b non-zero to show it is ignored
    q.push_back(mk(1, 16'hFFFF, 16'h1234, 8'hA5));
    q.push_back(mk(2, 16'h0000, 16'hFFFF, 8'h5A));
    q.push_back(mk(1, 16'h0FFF, 16'hFFFF, 8'h13));
    for (int i = 0; i < 400; i++) begin
      int a, b;
      a = $urandom % 65536;
      b = $urandom % 65536;
      if (i % 4 == 0) a = a | 16'h0FFF;
      q.push_back(mk($urandom % 4, a, b, $urandom % 256));
    end
    repeat (2) @(posedge clk);
    rst = 1'b0;
    while (q.size() > 0) begin
      vec_t v;
      v = q.pop_front();
      @(posedge clk);
      op_sel   = v.op[1:0];
      opnd_a   = v.a[15:0];
      opnd_b   = v.b[15:0];
      flags_in = v.f[7:0];
      @(negedge clk);
      judge();
    end
    done = 1;
  end

  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule